// File: doc/BRIEF.md
# Static Key Grid Encoder with Debounce

The block turns key closures into a 6-bit character code, a function-key flag and a one-cycle strobe. Character keys sit on a static grid of 8 column lines and 6 row lines: pressing a key holds exactly one column line and one row line active for as long as the key is down, and nothing is scanned. A separate bank of eight function keys gives each key its own line. Any activity on either group starts one shared settle timer.

The timer runs only while the combined line pattern stays constant. Once the pattern has been steady for the full interval, the block samples it. A pattern with exactly one key is latched as a code, and the strobe pulses for one clock. An ambiguous pattern is dropped without a strobe. The block then waits until every line has been inactive for another full settle interval before it accepts the next key.

The key lines are asynchronous to the clock, so they pass through a synchronizer first. The settle interval is a parameter counted in clock cycles; its default of 500000 cycles is 10 ms at 50 MHz.

Top module: `key_grid_encoder`

## Requirements
- R1: After reset, `key_code_o` is 0, `fn_flag_o` is 0 and `key_strobe_o` is 0.
- R2: A grid key with column line c (bit c of `col_lines_i`) and row line r (bit r of `row_lines_i`) active, and no other line active, yields `key_code_o[5:3]` = c, `key_code_o[2:0]` = r and `fn_flag_o` = 0.
- R3: Function key j (bit j of `fn_lines_i`) alone yields `key_code_o[2:0]` = j, `key_code_o[5:3]` = 0 and `fn_flag_o` = 1.
- R4: `key_strobe_o` is high for exactly one cycle. It rises SYNC_STAGES + SETTLE_CYCLES + 1 rising clock edges after the first edge that sees a new steady pattern on the inputs, and `key_code_o` and `fn_flag_o` take their new values on that same edge.
- R5: If every line goes inactive, or the line pattern changes, before the settle count completes, the count starts again. The strobe then follows the timing of R4, measured from the last change.
- R6: A pattern that is not exactly one key gives no strobe and leaves `key_code_o` and `fn_flag_o` unchanged. This covers two or more columns, two or more rows, a column without a row, two or more function lines, and function and grid lines active together.
- R7: After a key is sampled, no further strobe is issued until all lines have been inactive for SETTLE_CYCLES consecutive cycles. A line that becomes active again before then returns the block to the held state without a strobe.
- R8: `key_code_o` and `fn_flag_o` change only in a cycle where `key_strobe_o` is high, and they hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_lines_i | input | 8 | Grid column lines, active high, asynchronous |
| row_lines_i | input | 6 | Grid row lines, active high, asynchronous |
| fn_lines_i | input | 8 | Function key lines, one per key, active high, asynchronous |
| key_code_o | output | 6 | Code of the last accepted key |
| fn_flag_o | output | 1 | Set when the last accepted key was a function key |
| key_strobe_o | output | 1 | One-cycle pulse when a key is accepted |

## Verification
With two synchronizer stages and a settle interval of N cycles, a key pattern applied just after an edge gives a strobe after exactly N + 3 rising edges. A release applied the same way returns the block to idle after N + 3 edges. The bench drives every input on a falling edge. It reads the outputs on the falling edge after N + 2, N + 3 and N + 4 rising edges, and expects low, high and low again, with the new code present in the high cycle. For bounces and rejected patterns, it watches the strobe over a window several cycles longer than N + 3 and confirms that the code outputs have not moved.

// File: rtl/key_grid_pkg.sv
// Shared types for the key grid encoder.
package key_grid_pkg;

    // States of the shared settle timer.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,  // no line active
        ST_PRESS   = 2'd1,  // lines active, waiting for a steady pattern
        ST_HELD    = 2'd2,  // pattern sampled, waiting for release
        ST_RELEASE = 2'd3   // all lines inactive, waiting for a quiet interval
    } settle_state_e;

endpackage

// File: rtl/key_line_sync.sv
// Brings a vector of asynchronous key lines into the clock domain.
// Assumes: every bit is independent; STAGES >= 2 gives a fixed latency of
// STAGES rising edges.
module key_line_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines_i,
    output logic [WIDTH-1:0] lines_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the raw lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= lines_i;
                end
            end else begin : g_next
                // Each later flop takes the stage before it.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign lines_o = stage_q[STAGES-1];

endmodule

// File: rtl/key_onehot_index.sv
// Reports whether a line group has zero, exactly one or several lines
// active, and gives the index of the active line.
// Assumes: the index is meaningful only when single_o is high.
module key_onehot_index #(
    parameter int WIDTH = 8,
    parameter int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] lines_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             none_o,
    output logic             single_o
);

    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [CNT_W-1:0] active_cnt;

    // Count the active lines and record the position of the highest one.
    always_comb begin
        active_cnt = '0;
        idx_o      = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (lines_i[i]) begin
                active_cnt = active_cnt + 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
    end

    // Turn the count into the two classification flags.
    always_comb begin
        none_o   = (active_cnt == '0);
        single_o = (active_cnt == CNT_W'(1));
    end

endmodule

// File: rtl/key_settle_fsm.sv
// Shared settle timer for both key groups. It runs while the combined line
// pattern stays constant, pulses accept_o when the pattern has been steady
// for SETTLE_CYCLES cycles, and then requires an equally long quiet
// interval before it arms again.
// Assumes: the inputs are already synchronized; SETTLE_CYCLES >= 1.
module key_settle_fsm
    import key_grid_pkg::*;
#(
    parameter int LINES_W       = 22,
    parameter int SETTLE_CYCLES = 500000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES_W-1:0] lines_i,
    output logic               accept_o
);

    localparam int            CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    settle_state_e       state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic [LINES_W-1:0]  prev_q;
    logic                any_active;
    logic                changed;

    // Detect activity and any change of pattern since the last cycle.
    always_comb begin
        any_active = |lines_i;
        changed    = (lines_i != prev_q);
    end

    // Next state, counter and accept pulse.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (any_active) state_d = ST_PRESS;
            end
            ST_PRESS: begin
                if (!any_active) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (changed) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    accept_o = 1'b1;
                    state_d  = ST_HELD;
                    cnt_d    = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HELD: begin
                cnt_d = '0;
                if (!any_active) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (any_active) begin
                    state_d = ST_HELD;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Register the state, the counter and the previous pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= lines_i;
        end
    end

    // R7: once a pattern is accepted the timer waits for release.
    a_r7_accept_then_held: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (state_q == ST_HELD));

    // R5: a pattern change during the press window restarts the count.
    a_r5_restart_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRESS && any_active && changed) |=> (cnt_q == '0));

    // R5: lines dropping during the press window return the timer to idle.
    a_r5_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRESS && !any_active) |=> (state_q == ST_IDLE));

    // R7: activity during the quiet window goes back to held, never to idle.
    a_r7_quiet_broken: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && any_active) |=> (state_q == ST_HELD));

endmodule

// File: rtl/key_grid_encoder.sv
// Top of the key grid encoder. It synchronizes the grid and function lines,
// classifies the steady pattern, and, when the shared settle timer accepts
// a single-key pattern, latches its code and pulses the strobe.
// Assumes: the line groups are active high and hold statically while a
// key is down; the function index fits in the code width.
module key_grid_encoder #(
    parameter int NUM_COLS      = 8,
    parameter int NUM_ROWS      = 6,
    parameter int NUM_FKEYS     = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 500000
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [NUM_COLS-1:0]                          col_lines_i,
    input  logic [NUM_ROWS-1:0]                          row_lines_i,
    input  logic [NUM_FKEYS-1:0]                         fn_lines_i,
    output logic [$clog2(NUM_COLS)+$clog2(NUM_ROWS)-1:0] key_code_o,
    output logic                                         fn_flag_o,
    output logic                                         key_strobe_o
);

    localparam int COL_IDX_W = $clog2(NUM_COLS);
    localparam int ROW_IDX_W = $clog2(NUM_ROWS);
    localparam int FN_IDX_W  = $clog2(NUM_FKEYS);
    localparam int CODE_W    = COL_IDX_W + ROW_IDX_W;
    localparam int LINES_W   = NUM_COLS + NUM_ROWS + NUM_FKEYS;

    logic [LINES_W-1:0]   raw_lines, sync_lines;
    logic [NUM_COLS-1:0]  col_s;
    logic [NUM_ROWS-1:0]  row_s;
    logic [NUM_FKEYS-1:0] fn_s;

    logic [COL_IDX_W-1:0] col_idx;
    logic [ROW_IDX_W-1:0] row_idx;
    logic [FN_IDX_W-1:0]  fn_idx;
    logic col_none, col_one, row_none, row_one, fn_none, fn_one;

    logic              grid_valid, fn_valid, accept;
    logic [CODE_W-1:0] next_code;
    logic [CODE_W-1:0] code_q;
    logic              fn_q, strobe_q;

    assign raw_lines = {col_lines_i, row_lines_i, fn_lines_i};

    key_line_sync #(
        .WIDTH  (LINES_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (raw_lines),
        .lines_o (sync_lines)
    );

    assign {col_s, row_s, fn_s} = sync_lines;

    key_onehot_index #(.WIDTH(NUM_COLS), .IDX_W(COL_IDX_W)) u_col_idx (
        .lines_i  (col_s),
        .idx_o    (col_idx),
        .none_o   (col_none),
        .single_o (col_one)
    );

    key_onehot_index #(.WIDTH(NUM_ROWS), .IDX_W(ROW_IDX_W)) u_row_idx (
        .lines_i  (row_s),
        .idx_o    (row_idx),
        .none_o   (row_none),
        .single_o (row_one)
    );

    key_onehot_index #(.WIDTH(NUM_FKEYS), .IDX_W(FN_IDX_W)) u_fn_idx (
        .lines_i  (fn_s),
        .idx_o    (fn_idx),
        .none_o   (fn_none),
        .single_o (fn_one)
    );

    key_settle_fsm #(
        .LINES_W       (LINES_W),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_i  (sync_lines),
        .accept_o (accept)
    );

    // Classify the steady pattern and form the candidate code.
    always_comb begin
        grid_valid = col_one && row_one && fn_none;
        fn_valid   = fn_one && col_none && row_none;
        if (fn_valid) next_code = CODE_W'(fn_idx);
        else          next_code = {col_idx, row_idx};
    end

    // Latch the code and pulse the strobe when a single key is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            fn_q     <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= accept && (grid_valid || fn_valid);
            if (accept && (grid_valid || fn_valid)) begin
                code_q <= next_code;
                fn_q   <= fn_valid;
            end
        end
    end

    assign key_code_o   = code_q;
    assign fn_flag_o    = fn_q;
    assign key_strobe_o = strobe_q;

    // R4: the strobe never lasts longer than one cycle.
    a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        key_strobe_o |=> !key_strobe_o);

    // R8: the code outputs move only together with a strobe.
    a_r8_code_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(key_code_o) || !$stable(fn_flag_o)) |-> key_strobe_o);

    // R6: a strobe follows a cycle in which some line was active.
    a_r6_strobe_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
        key_strobe_o |-> $past(|sync_lines));

    // R3: a function key code never carries grid column bits.
    a_r3_fn_code_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (key_strobe_o && fn_flag_o) |-> (key_code_o[CODE_W-1:FN_IDX_W] == '0));

endmodule

// File: tb/sim_key_grid_encoder.sv
// Directed bench for the key grid encoder: one task per scenario.
module sim_key_grid_encoder;

    localparam int ST  = 8;          // settle interval used in the bench
    localparam int LAT = 2 + ST + 1; // rising edges from drive to strobe

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] col = '0;
    logic [5:0] row = '0;
    logic [7:0] fk  = '0;
    logic [5:0] code;
    logic       fnf;
    logic       stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    key_grid_encoder #(
        .NUM_COLS(8), .NUM_ROWS(6), .NUM_FKEYS(8),
        .SYNC_STAGES(2), .SETTLE_CYCLES(ST)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .col_lines_i(col), .row_lines_i(row), .fn_lines_i(fk),
        .key_code_o(code), .fn_flag_o(fnf), .key_strobe_o(stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [7:0] c, input logic [5:0] r, input logic [7:0] f);
        col = c; row = r; fk = f;
    endtask

    // Expect a strobe exactly LAT edges after the last drive.
    task automatic expect_strobe(input int exp_code, input bit exp_fn, input string tag);
        repeat (LAT - 1) step();
        chk(stb == 1'b0, {tag, " strobe early"}, int'(stb), 0);
        step();
        chk(stb == 1'b1, {tag, " strobe due"}, int'(stb), 1);
        chk(code == 6'(exp_code), {tag, " code"}, int'(code), exp_code);
        chk(fnf == exp_fn, {tag, " fn flag"}, int'(fnf), int'(exp_fn));
        step();
        chk(stb == 1'b0, {tag, " strobe width (R4)"}, int'(stb), 0);
    endtask

    // Watch a window for no strobe and unchanged outputs.
    task automatic expect_quiet(input int cycles, input string tag);
        logic [5:0] c0 = code;
        logic       f0 = fnf;
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            step();
            if (stb) seen = 1'b1;
        end
        chk(!seen, {tag, " no strobe"}, int'(seen), 0);
        chk(code == c0 && fnf == f0, {tag, " outputs held (R8)"}, int'({fnf, code}), int'({f0, c0}));
    endtask

    // Release all lines and wait out the quiet interval.
    task automatic release_all(input string tag);
        drive('0, '0, '0);
        expect_quiet(LAT + 1, {tag, " release"});
    endtask

    task automatic t_reset();
        chk(code == 6'd0, "R1 code", int'(code), 0);
        chk(fnf == 1'b0, "R1 fn flag", int'(fnf), 0);
        chk(stb == 1'b0, "R1 strobe", int'(stb), 0);
    endtask

    task automatic t_grid_key(input int c, input int r);
        drive(8'(1 << c), 6'(1 << r), '0);
        expect_strobe(c * 8 + r, 1'b0, $sformatf("R2 R4 grid c%0d r%0d", c, r));
        release_all("R2");
    endtask

    task automatic t_fn_key(input int j);
        drive('0, '0, 8'(1 << j));
        expect_strobe(j, 1'b1, $sformatf("R3 fn %0d", j));
        release_all("R3");
    endtask

    task automatic t_reject(input logic [7:0] c, input logic [5:0] r, input logic [7:0] f, input string tag);
        drive(c, r, f);
        expect_quiet(LAT + 6, {"R6 ", tag});
        release_all("R6");
    endtask

    task automatic t_bounce_drop();
        drive(8'h04, 6'h02, '0);
        repeat (4) step();
        drive('0, '0, '0);
        step();
        drive(8'h04, 6'h02, '0);
        expect_strobe(2 * 8 + 1, 1'b0, "R5 drop bounce");
        release_all("R5");
    endtask

    task automatic t_bounce_change();
        drive(8'h01, 6'h01, '0);
        repeat (5) step();
        drive(8'h20, 6'h10, '0);
        expect_strobe(5 * 8 + 4, 1'b0, "R5 pattern change");
        release_all("R5");
    endtask

    task automatic t_hold_rules();
        drive(8'h08, 6'h08, '0);
        expect_strobe(3 * 8 + 3, 1'b0, "R7 first key");
        expect_quiet(LAT + 4, "R7 key held");
        drive('0, '0, '0);
        repeat (4) step();
        drive('0, '0, 8'h40);
        expect_quiet(LAT + 6, "R7 early repress");
        release_all("R7");
        drive('0, '0, 8'h40);
        expect_strobe(6, 1'b1, "R7 after full release");
        release_all("R7");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_grid_key(0, 0);
        t_grid_key(7, 5);
        t_grid_key(3, 2);
        t_fn_key(0);
        t_fn_key(7);
        t_reject(8'h03, 6'h01, '0, "two columns");
        t_reject(8'h10, 6'h05, '0, "two rows");
        t_reject(8'h10, 6'h00, '0, "column only");
        t_reject('0, '0, 8'h81, "two fn lines");
        t_reject(8'h02, 6'h02, 8'h01, "mixed groups");
        t_bounce_drop();
        t_bounce_change();
        t_hold_rules();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule